// File: doc/BRIEF.md
# Vector register group legality checker

This block sits in the decode stage of a vector unit. For each vector arithmetic instruction it looks at the destination and source register numbers, the signed group-multiplier field and the vill bit. It then decides whether the register operands form legal groups for the operand shape the instruction uses. When they do not, it raises an illegal flag and gives a reason code that the trap logic can use. The result is registered, so it appears one clock after the decode fields are presented.

The operand shape is one of six classes: single-width, widening with two narrow sources, widening with a wide second source, narrowing, mask-producing compare, or reduction. A separate input says whether the first source is a vector register or a scalar/immediate. Each class has its own alignment rules and partial-overlap rules. Groups smaller than one register always count as aligned. For overlap purposes they count as one register.

Top module: `vreg_group_check`

## Requirements
- R1: When `vill_i` is 1, the next result is illegal with reason 1, whatever the other inputs are.
- R2: A multiplier code of 3'b100 is illegal (reason 2) for every class. For the widening classes (shape 1 and 2) and the narrowing class (shape 3), code 3 (eight registers) is also illegal (reason 2). Codes 0..3 mean 1, 2, 4 and 8 registers; codes 7, 6 and 5 mean 1/2, 1/4 and 1/8.
- R3: Single-width (shape 0) requires vd, vs2, and vs1 (only when `vv_i`=1) to be multiples of the group size. A misaligned operand gives reason 3. This class has no overlap rule, and fractional sizes are always legal.
- R4: Widening with narrow sources (shape 1) requires vd, vs2 and vs1 (when `vv_i`=1) to be aligned to twice the group size. The destination (twice the size) must not overlap vs2 or vs1 (when `vv_i`=1), except as described in R5. A violation gives reason 4.
- R5: Widening with a wide vs2 (shape 2) requires vd and vs2 aligned to twice the group size and vs1 aligned to the group size. The overlap rule applies only between vd and vs1, and only when `vv_i`=1. At one register or more, a source that starts above vd, overlaps it, and does not reach the next source-sized slot above it is allowed. Below one register, any overlap is illegal.
- R6: Narrowing (shape 3) requires vd aligned to the group size, vs2 aligned to twice it, and vs1 (when `vv_i`=1) aligned to it. If vd differs from vs2, any overlap between vd and vs2 is reason 4.
- R7: Mask-producing (shape 4) treats vd as one register, with no alignment rule on vd. vs2, and vs1 when `vv_i`=1, must be aligned to the group size. vd may not overlap either of them unless it equals that source register.
- R8: Reduction (shape 5) checks only that vs2 is aligned to the group size. vd and vs1 are ignored.
- R9: Reason codes are 0 legal, 1 vill, 2 bad multiplier, 3 misalignment and 4 overlap. The first failing check in that order wins. `illegal_o` is 1 exactly when the reason is non-zero.
- R10: Outputs update on the rising clock edge after the inputs are applied and hold between edges. While `rst_i` (synchronous, active high) is asserted, the outputs are legal with reason 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| vill_i | input | 1 | Vector type is invalid |
| vlmul_i | input | 3 | Signed group multiplier code |
| shape_i | input | 3 | Operand shape class 0..5 |
| vv_i | input | 1 | vs1 is a vector register |
| vd_i | input | 5 | Destination register number |
| vs2_i | input | 5 | Second source register number |
| vs1_i | input | 5 | First source register number |
| illegal_o | output | 1 | Instruction must raise illegal-instruction |
| reason_o | output | 3 | Reason code |

## Verification
A wrong size or wrong log2 value routed to one of the alignment or overlap units appears as a wrong reason code. It shows on the first rising edge after an operand pattern that sits on the boundary of that rule. For this reason the directed cases place sources exactly on the top half of a widened destination, one register off an aligned boundary, and equal to the destination. A wrong priority among failing checks appears only when two checks fail together, so cases with both a misaligned operand and an overlap are included. Because the result is a single register stage, every error is visible exactly one cycle after the stimulus.

// File: rtl/vgc_pkg.sv
package vgc_pkg;

    localparam int LOG_W = 4;

    typedef enum logic [2:0] {
        SHP_SAME     = 3'd0,
        SHP_WIDEN_NN = 3'd1,
        SHP_WIDEN_W  = 3'd2,
        SHP_NARROW   = 3'd3,
        SHP_MASK     = 3'd4,
        SHP_REDUCE   = 3'd5
    } shape_e;

    typedef enum logic [2:0] {
        RSN_OK      = 3'd0,
        RSN_VILL    = 3'd1,
        RSN_LMUL    = 3'd2,
        RSN_ALIGN   = 3'd3,
        RSN_OVERLAP = 3'd4
    } reason_e;

    typedef struct packed {
        logic    illegal;
        reason_e reason;
    } verdict_t;

endpackage

// File: rtl/vgc_lmul_decode.sv
module vgc_lmul_decode #(
    parameter int LW = 4
) (
    input  logic                 [2:0]    code_i,
    output logic signed          [LW-1:0] lg_o,
    output logic                          ok_o
);
    always_comb begin
        lg_o = $signed({{(LW-3){code_i[2]}}, code_i});
        ok_o = (code_i != 3'b100);
    end
endmodule

// File: rtl/vgc_align.sv
module vgc_align #(
    parameter int AW = 5,
    parameter int LW = 4
) (
    input  logic        [AW-1:0] idx_i,
    input  logic signed [LW-1:0] lg_i,
    input  logic                 en_i,
    output logic                 ok_o
);
    logic low_set;

    always_comb begin
        low_set = 1'b0;
        for (int k = 0; k < AW; k++) begin
            if (k < int'(lg_i) && idx_i[k]) low_set = 1'b1;
        end
        ok_o = !en_i || !low_set;
    end
endmodule

// File: rtl/vgc_overlap.sv
module vgc_overlap #(
    parameter int AW = 5,
    parameter int LW = 4
) (
    input  logic        [AW-1:0] dst_i,
    input  logic        [AW-1:0] src_i,
    input  logic signed [LW-1:0] dst_lg_i,
    input  logic signed [LW-1:0] src_lg_i,
    input  logic                 en_i,
    input  logic                 widen_i,
    input  logic                 same_ok_i,
    output logic                 clash_o
);
    localparam int SW = AW + 3;

    logic [SW-1:0] pa, pb, sa, sb, pnext;
    logic          hit_main, hit_next, top_part;

    function automatic logic hits(input logic [SW-1:0] s0, input logic [SW-1:0] z0,
                                  input logic [SW-1:0] s1, input logic [SW-1:0] z1);
        logic [SW-1:0] e0, e1, hi, lo;
        e0 = s0 + z0;
        e1 = s1 + z1;
        hi = (e0 > e1) ? e0 : e1;
        lo = (s0 < s1) ? s0 : s1;
        return (hi - lo) < (z0 + z1);
    endfunction

    always_comb begin
        pa       = SW'(dst_i);
        pb       = SW'(src_i);
        sa       = (dst_lg_i > 0) ? (SW'(1) << dst_lg_i[LW-2:0]) : SW'(1);
        sb       = (src_lg_i > 0) ? (SW'(1) << src_lg_i[LW-2:0]) : SW'(1);
        pnext    = pb + sb;
        hit_main = hits(pa, sa, pb, sb);
        hit_next = hits(pa, sa, pnext, sb);
        top_part = widen_i && (pa < pb) && !hit_next;
        clash_o  = en_i && hit_main && !top_part && !(same_ok_i && (dst_i == src_i));
    end
endmodule

// File: rtl/vreg_group_check.sv
module vreg_group_check
    import vgc_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              vill_i,
    input  logic [2:0]        vlmul_i,
    input  logic [2:0]        shape_i,
    input  logic              vv_i,
    input  logic [REG_AW-1:0] vd_i,
    input  logic [REG_AW-1:0] vs2_i,
    input  logic [REG_AW-1:0] vs1_i,
    output logic              illegal_o,
    output logic [2:0]        reason_o
);
    localparam int LW     = LOG_W;
    localparam int N_OPND = 3;
    localparam int N_PAIR = 2;

    logic signed [LW-1:0] lg, lg2;
    logic                 code_ok;

    logic [REG_AW-1:0]    op_idx [N_OPND];
    logic signed [LW-1:0] al_lg  [N_OPND];
    logic [N_OPND-1:0]    al_en, al_ok;

    logic [REG_AW-1:0]    ov_src [N_PAIR];
    logic signed [LW-1:0] ov_dlg, ov_slg;
    logic [N_PAIR-1:0]    ov_en, ov_clash;
    logic                 ov_wid, ov_same;

    logic                 too_big, lmul_bad;
    verdict_t             res_d, res_q;
    logic                 primed_q;
    shape_e               shp;

    vgc_lmul_decode #(.LW(LW)) u_lmul (
        .code_i (vlmul_i),
        .lg_o   (lg),
        .ok_o   (code_ok)
    );

    assign lg2       = lg + LW'(1);
    assign shp       = shape_e'(shape_i);
    assign op_idx[0] = vd_i;
    assign op_idx[1] = vs2_i;
    assign op_idx[2] = vs1_i;
    assign ov_src[0] = vs2_i;
    assign ov_src[1] = vs1_i;

    // Route group sizes and rule enables per operand shape
    always_comb begin
        al_en   = '0;
        al_lg[0] = lg;
        al_lg[1] = lg;
        al_lg[2] = lg;
        ov_en   = '0;
        ov_dlg  = lg2;
        ov_slg  = lg;
        ov_wid  = 1'b0;
        ov_same = 1'b0;
        too_big = 1'b0;
        unique case (shp)
            SHP_SAME: begin
                al_en = {vv_i, 1'b1, 1'b1};
            end
            SHP_WIDEN_NN: begin
                al_en    = {vv_i, 1'b1, 1'b1};
                al_lg[0] = lg2;
                al_lg[1] = lg2;
                al_lg[2] = lg2;
                ov_en    = {vv_i, 1'b1};
                ov_wid   = !lg[LW-1];
                too_big  = (lg == LW'(3));
            end
            SHP_WIDEN_W: begin
                al_en    = {vv_i, 1'b1, 1'b1};
                al_lg[0] = lg2;
                al_lg[1] = lg2;
                ov_en    = {vv_i, 1'b0};
                ov_wid   = !lg[LW-1];
                too_big  = (lg == LW'(3));
            end
            SHP_NARROW: begin
                al_en    = {vv_i, 1'b1, 1'b1};
                al_lg[1] = lg2;
                ov_en    = 2'b01;
                ov_dlg   = lg;
                ov_slg   = lg2;
                ov_same  = 1'b1;
                too_big  = (lg == LW'(3));
            end
            SHP_MASK: begin
                al_en   = {vv_i, 1'b1, 1'b0};
                ov_en   = {vv_i, 1'b1};
                ov_dlg  = '0;
                ov_same = 1'b1;
            end
            SHP_REDUCE: begin
                al_en = 3'b010;
            end
            default: begin
                al_en = '0;
            end
        endcase
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_align
        vgc_align #(.AW(REG_AW), .LW(LW)) u_align (
            .idx_i (op_idx[g]),
            .lg_i  (al_lg[g]),
            .en_i  (al_en[g]),
            .ok_o  (al_ok[g])
        );
    end

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        vgc_overlap #(.AW(REG_AW), .LW(LW)) u_ovl (
            .dst_i     (vd_i),
            .src_i     (ov_src[p]),
            .dst_lg_i  (ov_dlg),
            .src_lg_i  (ov_slg),
            .en_i      (ov_en[p]),
            .widen_i   (ov_wid),
            .same_ok_i (ov_same),
            .clash_o   (ov_clash[p])
        );
    end

    assign lmul_bad = !code_ok || too_big;

    always_comb begin
        res_d.illegal = vill_i || lmul_bad || !(&al_ok) || (|ov_clash);
        if (vill_i)             res_d.reason = RSN_VILL;
        else if (lmul_bad)      res_d.reason = RSN_LMUL;
        else if (!(&al_ok))     res_d.reason = RSN_ALIGN;
        else if (|ov_clash)     res_d.reason = RSN_OVERLAP;
        else                    res_d.reason = RSN_OK;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            res_q    <= '{illegal: 1'b0, reason: RSN_OK};
            primed_q <= 1'b0;
        end else begin
            res_q    <= res_d;
            primed_q <= 1'b1;
        end
    end

    assign illegal_o = res_q.illegal;
    assign reason_o  = res_q.reason;

    // R1: vill reported first
    a_r1_vill_first: assert property (@(posedge clk_i) disable iff (rst_i)
        primed_q && $past(vill_i) |-> reason_o == 3'd1);

    // R2: reserved multiplier code
    a_r2_reserved_code: assert property (@(posedge clk_i) disable iff (rst_i)
        primed_q && !$past(vill_i) && $past(vlmul_i) == 3'b100 |-> reason_o == 3'd2);

    // R3: fractional single-width never illegal
    a_r3_frac_single_legal: assert property (@(posedge clk_i) disable iff (rst_i)
        primed_q && !$past(vill_i) && $past(shape_i) == 3'd0 && $past(vlmul_i[2])
        && $past(vlmul_i[1:0]) != 2'b00 |-> !illegal_o);

    // R7: one-register mask compares cannot clash
    a_r7_mask_unit_no_clash: assert property (@(posedge clk_i) disable iff (rst_i)
        primed_q && !$past(vill_i) && $past(shape_i) == 3'd4 && $past(vlmul_i) == 3'd0
        |-> reason_o != 3'd4);

    // R8: reduction at one register always legal
    a_r8_reduce_unit_legal: assert property (@(posedge clk_i) disable iff (rst_i)
        primed_q && !$past(vill_i) && $past(shape_i) == 3'd5 && $past(vlmul_i) == 3'd0
        |-> !illegal_o);

    // R9: flag and reason agree
    a_r9_flag_matches_code: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o == (reason_o != 3'd0));

endmodule

// File: tb/tb_vreg_group_check.sv
module tb_vreg_group_check;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vill = 1'b0;
    logic [2:0] vlmul = 3'd0;
    logic [2:0] shape = 3'd0;
    logic       vv = 1'b0;
    logic [4:0] vd = '0, vs2 = '0, vs1 = '0;
    logic       illegal;
    logic [2:0] reason;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vreg_group_check dut (
        .clk_i(clk), .rst_i(rst), .vill_i(vill), .vlmul_i(vlmul), .shape_i(shape),
        .vv_i(vv), .vd_i(vd), .vs2_i(vs2), .vs1_i(vs1),
        .illegal_o(illegal), .reason_o(reason)
    );

    task automatic expect_out(input string tag, input logic [2:0] exp);
        total++;
        if (reason !== exp || illegal !== (exp != 3'd0)) begin
            bad++;
            $display("FAIL %s: reason=%0d illegal=%0b expected reason=%0d illegal=%0b",
                     tag, reason, illegal, exp, (exp != 3'd0));
        end
    endtask

    task automatic run_case(input string tag, input logic [2:0] s, input logic v,
                            input logic vl, input logic [2:0] lm, input logic [4:0] d,
                            input logic [4:0] b, input logic [4:0] a, input logic [2:0] exp);
        @(negedge clk);
        shape = s; vv = v; vill = vl; vlmul = lm; vd = d; vs2 = b; vs1 = a;
        @(posedge clk);
        #1;
        expect_out(tag, exp);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1;
        expect_out("R10 reset state", 3'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_vill;
        run_case("R1 vill alone",          3'd0, 1, 1, 3'd0, 5'd0, 5'd4, 5'd8, 3'd1);
        run_case("R1 vill over bad code",  3'd1, 1, 1, 3'd4, 5'd1, 5'd1, 5'd1, 3'd1);
    endtask

    task automatic t_lmul;
        run_case("R2 reserved code",       3'd0, 1, 0, 3'd4, 5'd0, 5'd4, 5'd8, 3'd2);
        run_case("R2 widen x8",            3'd1, 1, 0, 3'd3, 5'd0, 5'd16, 5'd8, 3'd2);
        run_case("R2 narrow x8",           3'd3, 0, 0, 3'd3, 5'd0, 5'd16, 5'd0, 3'd2);
        run_case("R2 single x8 ok",        3'd0, 1, 0, 3'd3, 5'd8, 5'd16, 5'd24, 3'd0);
        run_case("R2 mask x8 ok",          3'd4, 1, 0, 3'd3, 5'd0, 5'd8, 5'd16, 3'd0);
    endtask

    task automatic t_single;
        run_case("R3 aligned x4",          3'd0, 1, 0, 3'd2, 5'd4, 5'd8, 5'd12, 3'd0);
        run_case("R3 vs1 misaligned",      3'd0, 1, 0, 3'd2, 5'd4, 5'd8, 5'd6, 3'd3);
        run_case("R3 vs1 scalar ignored",  3'd0, 0, 0, 3'd2, 5'd4, 5'd8, 5'd6, 3'd0);
        run_case("R3 vd misaligned",       3'd0, 0, 0, 3'd1, 5'd3, 5'd8, 5'd0, 3'd3);
        run_case("R3 fractional",          3'd0, 1, 0, 3'd7, 5'd3, 5'd5, 5'd7, 3'd0);
    endtask

    task automatic t_widen_nn;
        run_case("R4 legal x2",            3'd1, 1, 0, 3'd1, 5'd4, 5'd8, 5'd12, 3'd0);
        run_case("R4 vs2 misaligned",      3'd1, 1, 0, 3'd1, 5'd4, 5'd6, 5'd12, 3'd3);
        run_case("R4 vs2 on vd",           3'd1, 1, 0, 3'd1, 5'd4, 5'd4, 5'd12, 3'd4);
        run_case("R4 frac overlap",        3'd1, 1, 0, 3'd7, 5'd3, 5'd3, 5'd9, 3'd4);
        run_case("R4 frac disjoint",       3'd1, 1, 0, 3'd7, 5'd3, 5'd4, 5'd5, 3'd0);
        run_case("R4 scalar vs1 ignored",  3'd1, 0, 0, 3'd1, 5'd4, 5'd8, 5'd4, 3'd0);
    endtask

    task automatic t_widen_w;
        run_case("R5 top part x2",         3'd2, 1, 0, 3'd1, 5'd8, 5'd0, 5'd10, 3'd0);
        run_case("R5 low part x2",         3'd2, 1, 0, 3'd1, 5'd8, 5'd0, 5'd8, 3'd4);
        run_case("R5 vs1 misaligned",      3'd2, 1, 0, 3'd1, 5'd8, 5'd0, 5'd9, 3'd3);
        run_case("R5 top part x1",         3'd2, 1, 0, 3'd0, 5'd8, 5'd0, 5'd9, 3'd0);
        run_case("R5 low part x1",         3'd2, 1, 0, 3'd0, 5'd8, 5'd0, 5'd8, 3'd4);
        run_case("R5 frac equal",          3'd2, 1, 0, 3'd7, 5'd5, 5'd0, 5'd5, 3'd4);
        run_case("R5 frac apart",          3'd2, 1, 0, 3'd7, 5'd5, 5'd0, 5'd6, 3'd0);
        run_case("R5 scalar no overlap",   3'd2, 0, 0, 3'd1, 5'd8, 5'd0, 5'd8, 3'd0);
    endtask

    task automatic t_narrow;
        run_case("R6 vd in vs2 high",      3'd3, 1, 0, 3'd1, 5'd2, 5'd0, 5'd6, 3'd4);
        run_case("R6 vd equals vs2",       3'd3, 1, 0, 3'd1, 5'd0, 5'd0, 5'd6, 3'd0);
        run_case("R6 disjoint",            3'd3, 1, 0, 3'd1, 5'd4, 5'd0, 5'd6, 3'd0);
        run_case("R6 vd misaligned",       3'd3, 1, 0, 3'd1, 5'd1, 5'd4, 5'd6, 3'd3);
        run_case("R6 vs2 misaligned",      3'd3, 1, 0, 3'd1, 5'd0, 5'd2, 5'd6, 3'd3);
        run_case("R6 frac equal",          3'd3, 0, 0, 3'd7, 5'd3, 5'd3, 5'd0, 3'd0);
        run_case("R6 frac adjacent",       3'd3, 0, 0, 3'd7, 5'd3, 5'd4, 5'd0, 3'd0);
    endtask

    task automatic t_mask;
        run_case("R7 legal x4",            3'd4, 1, 0, 3'd2, 5'd0, 5'd4, 5'd8, 3'd0);
        run_case("R7 vd inside vs2",       3'd4, 1, 0, 3'd2, 5'd5, 5'd4, 5'd8, 3'd4);
        run_case("R7 vd equals vs2",       3'd4, 1, 0, 3'd2, 5'd4, 5'd4, 5'd8, 3'd0);
        run_case("R7 vd inside vs1",       3'd4, 1, 0, 3'd2, 5'd9, 5'd0, 5'd8, 3'd4);
        run_case("R7 scalar vs1 ignored",  3'd4, 0, 0, 3'd2, 5'd9, 5'd0, 5'd8, 3'd0);
        run_case("R7 vs2 misaligned",      3'd4, 1, 0, 3'd2, 5'd0, 5'd2, 5'd8, 3'd3);
        run_case("R7 vd odd allowed",      3'd4, 1, 0, 3'd2, 5'd3, 5'd4, 5'd8, 3'd0);
    endtask

    task automatic t_reduce;
        run_case("R8 vd vs1 ignored",      3'd5, 1, 0, 3'd3, 5'd3, 5'd8, 5'd5, 3'd0);
        run_case("R8 vs2 misaligned",      3'd5, 1, 0, 3'd3, 5'd0, 5'd4, 5'd0, 3'd3);
    endtask

    task automatic t_priority;
        run_case("R9 align beats overlap", 3'd3, 1, 0, 3'd1, 5'd2, 5'd0, 5'd5, 3'd3);
        run_case("R9 lmul beats align",    3'd1, 1, 0, 3'd3, 5'd3, 5'd5, 5'd7, 3'd2);
    endtask

    task automatic t_timing;
        run_case("R10 setup overlap",      3'd4, 1, 0, 3'd2, 5'd5, 5'd4, 5'd8, 3'd4);
        @(negedge clk);
        shape = 3'd0; vv = 1'b0; vlmul = 3'd0; vd = 5'd1; vs2 = 5'd2;
        #1;
        expect_out("R10 holds before edge", 3'd4);
        @(posedge clk);
        #1;
        expect_out("R10 updates after edge", 3'd0);
    endtask

    initial begin
        t_reset();
        t_vill();
        t_lmul();
        t_single();
        t_widen_nn();
        t_widen_w();
        t_narrow();
        t_mask();
        t_reduce();
        t_priority();
        t_timing();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule